// File: doc/BRIEF.md
# Slow Peripheral Wait-State Sequencer

This block lets a fast CPU bus talk to one slow byte-wide peripheral, such as a real-time clock. When the peripheral is selected and the CPU starts a read or a write, the block raises the CPU wait line in that same cycle. It keeps the wait line raised while it drives the peripheral's own strobes. These are an address-latch pulse, then a read or write pulse that is stretched to the peripheral's minimum width, and then a hold window in which the address must stay valid. On a read, the block captures the peripheral's data byte on the last strobe clock and presents it to the CPU.

The strobe and hold lengths are set by 4-bit count inputs, so the same block can serve other slow devices. Each count is raised to a floor that comes from the peripheral's timing. At a 12 MHz CPU clock (about 83 ns per clock), a 500 ns write pulse needs 6 clocks and a 1 µs address hold needs 12 clocks. Accesses that do not select the device, such as fast SRAM cycles, pass with no wait at all. Address decoding and data buffering are done outside the block.

Top module: `slowdev_wait_seq`

## Requirements
- R1: While reset is asserted and after it is released, cpu_wait, per_ale, per_rd and per_wr are low, and cpu_rdata is zero.
- R2: In the idle state, cpu_wait goes high in the same cycle that dev_sel is high together with cpu_rd or cpu_wr. When dev_sel is low, a CPU strobe causes no wait and no peripheral strobe.
- R3: per_ale is high for the 2 clocks that follow the start clock. Then there is exactly 1 clock in which none of the peripheral strobes is high. The read or write pulse starts on the clock after that.
- R4: The peripheral pulse lasts max(strobe_len, 6) clocks. The pulse is on per_rd if the access began with cpu_rd, and on per_wr if it began with cpu_wr (cpu_wr wins if both are high).
- R5: After the pulse ends, cpu_wait stays high for max(hold_len, 12) more clocks, with all peripheral strobes low. It then drops.
- R6: On a read, cpu_rdata takes the per_rdata value present in the last pulse clock. It then keeps that value until the next read captures new data. Writes leave it unchanged.
- R7: If dev_sel drops partway through an access, the sequence is not shortened. Every phase keeps its full length.
- R8: After cpu_wait drops, the block starts no new access and raises no strobe until cpu_rd and cpu_wr are both low.
- R9: At most one of per_ale, per_rd and per_wr is high in any cycle. None of them is high unless cpu_wait is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 1 | Slow device selected by the external decoder |
| cpu_rd | input | 1 | CPU read strobe, active high |
| cpu_wr | input | 1 | CPU write strobe, active high |
| strobe_len | input | 4 | Requested pulse length in clocks (floor 6) |
| hold_len | input | 4 | Requested hold length in clocks (floor 12) |
| per_rdata | input | 8 | Data byte from the peripheral |
| cpu_wait | output | 1 | Wait request to the CPU |
| per_ale | output | 1 | Peripheral address-latch pulse |
| per_rd | output | 1 | Peripheral read pulse |
| per_wr | output | 1 | Peripheral write pulse |
| cpu_rdata | output | 8 | Captured read byte for the CPU |

## Verification
The hardest case to reach is the one where the CPU keeps its strobe high after the wait line has dropped. In that case the block must not start a second access. The stimulus reaches it by holding cpu_rd or cpu_wr high for two extra clocks in the release phase of every access. A second hard case is showing that read data is taken on the last pulse clock and not on an earlier one. To cover it, the bench drives the true byte on per_rdata only during that one clock and the inverted byte in every other clock. Random strobe and hold counts, including values below the floors, are mixed with accesses in which the select drops partway through.

// File: rtl/slowdev_pkg.sv
package slowdev_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/slowdev_seq_fsm.sv
module slowdev_seq_fsm
  import slowdev_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int MIN_STROBE = 6,
  parameter int MIN_HOLD   = 12,
  parameter int ALE_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_sel,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] hold_len,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             is_wr,
  output logic             start,
  output logic             stb_last
);
  localparam int SETUP_CYC = ALE_CYC + 1;
  localparam logic [CNT_W-1:0] MIN_S   = CNT_W'(MIN_STROBE);
  localparam logic [CNT_W-1:0] MIN_H   = CNT_W'(MIN_HOLD);
  localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] stb_q, hld_q, stb_eff, hld_eff;
  logic             wr_q;

  assign stb_eff = (strobe_len < MIN_S) ? MIN_S : strobe_len;
  assign hld_eff = (hold_len   < MIN_H) ? MIN_H : hold_len;

  assign start    = (state_q == ST_IDLE) && dev_sel && (cpu_rd || cpu_wr);
  assign stb_last = (state_q == ST_STROBE) && (cnt_q == stb_q - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ADDR;
        cnt_d   = '0;
      end
      ST_ADDR: if (cnt_q == SETUP_L) begin
        state_d = ST_STROBE;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_STROBE: if (stb_last) begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_HOLD: if (cnt_q == hld_q - 1'b1) begin
        state_d = ST_RELEASE;
        cnt_d   = '0;
      end else cnt_d = cnt_q + 1'b1;
      ST_RELEASE: if (!cpu_rd && !cpu_wr) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      hld_q <= '0;
      wr_q  <= 1'b0;
    end else if (start) begin
      stb_q <= stb_eff;
      hld_q <= hld_eff;
      wr_q  <= cpu_wr;
    end
  end

  assign state = state_q;
  assign cnt   = cnt_q;
  assign is_wr = wr_q;

  // R8: leaving release needs both CPU strobes idle
  a_r8_release_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELEASE && (cpu_rd || cpu_wr)) |=> (state_q == ST_RELEASE));
  // R7: once started, the sequence always reaches the pulse phase
  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && cnt_q == SETUP_L) |=> (state_q == ST_STROBE));
endmodule

// File: rtl/slowdev_strobe_gen.sv
module slowdev_strobe_gen
  import slowdev_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 8,
  parameter int ALE_CYC    = 2,
  parameter int MIN_STROBE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              is_wr,
  input  logic              start,
  input  logic              stb_last,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              cpu_wait,
  output logic              per_ale,
  output logic              per_rd,
  output logic              per_wr,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam logic [CNT_W-1:0] ALE_L = CNT_W'(ALE_CYC);

  logic [DATA_W-1:0] rdata_q;
  logic              cap_en;

  assign cpu_wait = start || (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_HOLD);
  assign per_ale  = (state == ST_ADDR) && (cnt < ALE_L);
  assign per_rd   = (state == ST_STROBE) && !is_wr;
  assign per_wr   = (state == ST_STROBE) && is_wr;
  assign cap_en   = stb_last && !is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= per_rdata;
  end
  assign cpu_rdata = rdata_q;

  // checker-side run length of the current peripheral pulse
  logic [CNT_W:0] run_q;
  logic           pulse;
  assign pulse = per_rd || per_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (pulse) run_q <= (&run_q) ? run_q : run_q + 1'b1;
    else            run_q <= '0;
  end

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({per_ale, per_rd, per_wr}) <= 1);
  a_r9_strobe_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ale || per_rd || per_wr) |-> cpu_wait);
  a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (run_q >= (CNT_W+1)'(MIN_STROBE)));
  a_r5_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> cpu_wait);
  a_r3_ale_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> ($past(!per_ale) && $past(per_ale, 2)));
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cpu_rdata));
endmodule

// File: rtl/slowdev_wait_seq.sv
module slowdev_wait_seq
  import slowdev_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 8,
  parameter int MIN_STROBE = 6,
  parameter int MIN_HOLD   = 12,
  parameter int ALE_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_sel,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [CNT_W-1:0]  strobe_len,
  input  logic [CNT_W-1:0]  hold_len,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              cpu_wait,
  output logic              per_ale,
  output logic              per_rd,
  output logic              per_wr,
  output logic [DATA_W-1:0] cpu_rdata
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_wr, start, stb_last;

  slowdev_seq_fsm #(
    .CNT_W(CNT_W), .MIN_STROBE(MIN_STROBE), .MIN_HOLD(MIN_HOLD), .ALE_CYC(ALE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .strobe_len(strobe_len), .hold_len(hold_len),
    .state(state), .cnt(cnt), .is_wr(is_wr), .start(start), .stb_last(stb_last)
  );

  slowdev_strobe_gen #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ALE_CYC(ALE_CYC), .MIN_STROBE(MIN_STROBE)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .is_wr(is_wr),
    .start(start), .stb_last(stb_last), .per_rdata(per_rdata),
    .cpu_wait(cpu_wait), .per_ale(per_ale), .per_rd(per_rd), .per_wr(per_wr),
    .cpu_rdata(cpu_rdata)
  );
endmodule

// File: tb/slowdev_wait_seq_test.sv
module slowdev_wait_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_sel, cpu_rd, cpu_wr;
  logic [3:0] strobe_len, hold_len;
  logic [7:0] per_rdata;
  logic       cpu_wait, per_ale, per_rd, per_wr;
  logic [7:0] cpu_rdata;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_rdata = 8'h00;

  always #10 clk = ~clk;

  slowdev_wait_seq uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .strobe_len(strobe_len), .hold_len(hold_len), .per_rdata(per_rdata),
    .cpu_wait(cpu_wait), .per_ale(per_ale), .per_rd(per_rd), .per_wr(per_wr),
    .cpu_rdata(cpu_rdata)
  );

  function automatic int floor_len(input int v, input int f);
    return (v < f) ? f : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_bus(input string req, input bit w, input bit a, input bit r, input bit wr_);
    check({cpu_wait, per_ale, per_rd, per_wr} == {w, a, r, wr_}, req,
          {cpu_wait, per_ale, per_rd, per_wr}, {w, a, r, wr_});
  endtask

  // one full access, starting and ending at a negedge
  task automatic run_access(input bit wr, input int sl, input int hl, input bit drop, input logic [7:0] d);
    int n = floor_len(sl, 6);
    int h = floor_len(hl, 12);
    int rel = 4 + n + h;
    strobe_len = sl[3:0]; hold_len = hl[3:0];
    dev_sel = 1'b1; cpu_rd = !wr; cpu_wr = wr; per_rdata = ~d;
    #1 check_bus("R2 wait on first select clock", 1, 0, 0, 0);
    for (int i = 1; i <= rel; i++) begin
      @(negedge clk);
      per_rdata = (i == 3 + n) ? d : ~d;
      if (drop && i == 2) dev_sel = 1'b0;  // R7 select dropped mid-cycle
      #1;
      if (!wr && i == 4 + n) exp_rdata = d;
      // R3 ale 1..2, gap 3; R4 pulse 4..3+n; R5 hold to 3+n+h
      check_bus(drop ? "R7 sequence length" : (i <= 3 ? "R3 address phase" :
                (i <= 3 + n ? "R4 pulse" : "R5 hold")),
                i <= 3 + n + h, i <= 2, !wr && i >= 4 && i <= 3 + n, wr && i >= 4 && i <= 3 + n);
      check(cpu_rdata == exp_rdata, "R6 read data", cpu_rdata, exp_rdata);
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      check_bus("R8 no restart while strobe held", 0, 0, 0, 0);
    end
    @(negedge clk);
    dev_sel = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    @(negedge clk); #1;
    check_bus("R8 back to idle", 0, 0, 0, 0);
    check(cpu_rdata == exp_rdata, "R6 data kept", cpu_rdata, exp_rdata);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; dev_sel = 0; cpu_rd = 0; cpu_wr = 0;
    strobe_len = 0; hold_len = 0; per_rdata = 8'hA5;
    repeat (3) @(negedge clk);
    #1 check_bus("R1 reset outputs", 0, 0, 0, 0);
    check(cpu_rdata == 8'h00, "R1 reset data", cpu_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk); #1 check_bus("R1 after reset", 0, 0, 0, 0);

    // R2 fast memory access: no select, no wait
    cpu_rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1 check_bus("R2 unselected read", 0, 0, 0, 0);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b1;
    @(negedge clk); #1 check_bus("R2 unselected write", 0, 0, 0, 0);
    cpu_wr = 1'b0;
    @(negedge clk);

    run_access(1'b0, 0, 0, 1'b0, 8'h3C);    // floors apply
    run_access(1'b1, 6, 12, 1'b0, 8'h00);   // exact floors, write
    run_access(1'b0, 15, 15, 1'b0, 8'hC3);  // maximum counts
    run_access(1'b1, 9, 3, 1'b1, 8'h00);    // R7 drop on write
    run_access(1'b0, 7, 14, 1'b1, 8'h5A);   // R7 drop on read
    for (int t = 0; t < 20; t++)
      run_access($urandom % 2, $urandom % 16, $urandom % 16, ($urandom % 4) == 0, 8'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule